// File: doc/BRIEF.md
# Four-Bit Up/Down Counter with Parallel Load

This block is a four-bit synchronous counter that can step up or down, take a parallel value, be cleared, or hold. Every change of the count happens on the rising clock edge. Clear is active low and outranks everything. Load outranks counting. Counting happens only while the count enable is high, and the direction input chooses between incrementing and decrementing. The count wraps in both directions.

A terminal-count flag is derived combinationally from the present count and the direction. It does not depend on the count enable. The four parallel-load bits are separate scalar ports, so each one can be tied to its own switch or pin. The state register is fully decoded: all sixteen encodings are legal counts, and every one has a defined successor. An upset or uninitialised value therefore cannot lock the block up.

Top module: `updn_load_counter`

## Requirements
- R1: When clear_n is low at a rising edge, the count becomes 0000 after that edge, whatever load, count_en, down and the data bits are.
- R2: When clear_n is high and load is high at a rising edge, the count becomes {din3,din2,din1,din0}, with din3 as the most significant bit, whatever count_en and down are.
- R3: When clear_n is high, load is low, count_en is high and down is 0, the count increments by one at the edge.
- R4: When clear_n is high, load is low, count_en is high and down is 1, the count decrements by one at the edge.
- R5: The count wraps: stepping up from 1111 gives 0000, and stepping down from 0000 gives 1111.
- R6: When clear_n is high and load and count_en are both low, the count keeps its value across the edge.
- R7: term is high exactly when down is 0 and the count is 1111, or when down is 1 and the count is 0000. It follows count and down without waiting for a clock edge, and count_en has no effect on it.
- R8: The count changes only at a rising clock edge. Input changes between edges leave the count unchanged until the next edge.
- R9: Every one of the sixteen count values can be loaded, and from each one a step up or a step down leads to its modular neighbour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| count_en | input | 1 | Count enable; the count steps only while this is high |
| clear_n | input | 1 | Synchronous clear, active low, highest priority |
| down | input | 1 | Direction: 0 steps up, 1 steps down |
| load | input | 1 | Parallel load strobe; outranks count_en |
| din3 | input | 1 | Load data, most significant bit |
| din2 | input | 1 | Load data, bit 2 |
| din1 | input | 1 | Load data, bit 1 |
| din0 | input | 1 | Load data, least significant bit |
| term | output | 1 | Terminal-count flag, depends on the direction |
| count | output | 4 | Present count |

## Verification
The hardest situations to reach are the wrap edges combined with a reversal of direction. One is the step from 0000 down to 1111: the counter arrives at 1111, but term must stay low there because the direction is down. The other is term staying high while the count is idle. Both are reached by loading a value one step away from the edge, stepping across it, and then reversing or dropping the enable.

Load values are swept across all sixteen codes, with a step up and a step down from each, so every successor is exercised. A separate test changes the inputs between clock edges to show that the count moves only on an edge.

// File: rtl/ctr_pkg.sv
// Shared definitions for the up/down load counter.
// Assumes a binary count whose width is set here once.
package ctr_pkg;
    localparam int CNT_W = 4;

    // Operation chosen for the coming edge, listed in priority order.
    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STEP  = 2'd2,
        OP_HOLD  = 2'd3
    } ctr_op_e;
endpackage

// File: rtl/ctr_op_sel.sv
// Priority decoder: clear beats load, load beats counting, and otherwise hold.
// Assumes all controls are synchronous to the counter clock.
module ctr_op_sel
    import ctr_pkg::*;
(
    input  logic    clear_n,
    input  logic    load,
    input  logic    count_en,
    output ctr_op_e op
);
    // Pick the operation with the highest priority that is requested.
    always_comb begin
        if (!clear_n)      op = OP_CLEAR;
        else if (load)     op = OP_LOAD;
        else if (count_en) op = OP_STEP;
        else               op = OP_HOLD;
    end
endmodule

// File: rtl/ctr_next.sv
// Next-count datapath. It is fully decoded, so every present value has a
// defined successor, and a step wraps modulo 2**W.
// Assumes the operation is already resolved by priority.
module ctr_next
    import ctr_pkg::*;
#(
    parameter int W = 4
) (
    input  ctr_op_e        op,
    input  logic           down,
    input  logic [W-1:0]   cur,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   nxt
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] stepped;

    // Modular step in the requested direction.
    always_comb stepped = down ? (cur - ONE) : (cur + ONE);

    // Select the successor for the chosen operation.
    always_comb begin
        case (op)
            OP_CLEAR: nxt = ZERO;
            OP_LOAD:  nxt = din;
            OP_STEP:  nxt = stepped;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/ctr_term.sv
// Terminal-count detector: flags the last value before a wrap in the
// current direction. It is purely combinational and ignores the enable.
module ctr_term #(
    parameter int W = 4
) (
    input  logic [W-1:0] cur,
    input  logic         down,
    output logic         term
);
    logic at_top;
    logic at_bottom;

    // Detect the two extreme values of the count.
    always_comb begin
        at_top    = &cur;
        at_bottom = ~|cur;
        term      = down ? at_bottom : at_top;
    end
endmodule

// File: rtl/updn_load_counter.sv
// Four-bit up/down counter with parallel load and synchronous active-low
// clear. Load bits arrive as scalars and are packed here, din3 being the MSB.
// Assumes one clock domain; the state register has no illegal encodings.
module updn_load_counter
    import ctr_pkg::*;
(
    input  logic             clk,
    input  logic             count_en,
    input  logic             clear_n,
    input  logic             down,
    input  logic             load,
    input  logic             din3,
    input  logic             din2,
    input  logic             din1,
    input  logic             din0,
    output logic             term,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] din_vec;
    logic [CNT_W-1:0] q;
    logic [CNT_W-1:0] q_nxt;
    ctr_op_e          op;

    // Gather the scalar load bits into a vector.
    always_comb din_vec = {din3, din2, din1, din0};

    ctr_op_sel u_sel (
        .clear_n  (clear_n),
        .load     (load),
        .count_en (count_en),
        .op       (op)
    );

    ctr_next #(.W(CNT_W)) u_next (
        .op   (op),
        .down (down),
        .cur  (q),
        .din  (din_vec),
        .nxt  (q_nxt)
    );

    // State register: clear, load, step and hold are all resolved in q_nxt.
    always_ff @(posedge clk) q <= q_nxt;

    ctr_term #(.W(CNT_W)) u_term (
        .cur  (q),
        .down (down),
        .term (term)
    );

    // Drive the count output.
    always_comb count = q;

    // Clear forces zero at the next edge.
    p_clear_r1: assert property (@(posedge clk)
        !clear_n |=> (count == '0));

    // Load captures the data bits regardless of the enable.
    p_load_r2: assert property (@(posedge clk) disable iff (!clear_n)
        load |=> (count == $past(din_vec)));

    // Step up.
    p_up_r3: assert property (@(posedge clk) disable iff (!clear_n)
        (!load && count_en && !down) |=> (count == $past(count) + ONE));

    // Step down.
    p_down_r4: assert property (@(posedge clk) disable iff (!clear_n)
        (!load && count_en && down) |=> (count == $past(count) - ONE));

    // Wrap from the top to zero when stepping up.
    p_wrap_r5: assert property (@(posedge clk) disable iff (!clear_n)
        (!load && count_en && !down && (&count)) |=> (count == '0));

    // Idle keeps the value.
    p_hold_r6: assert property (@(posedge clk) disable iff (!clear_n)
        (!load && !count_en) |=> $stable(count));

    // The flag only appears at one of the two extreme counts.
    p_term_r7: assert property (@(posedge clk) disable iff (!clear_n)
        term |-> ((count == '0) || (&count)));
endmodule

// File: tb/updn_load_counter_tb.sv
`timescale 1ns/1ps
module updn_load_counter_tb;
    logic       clk = 1'b0;
    logic       count_en = 1'b0;
    logic       clear_n = 1'b0;
    logic       down = 1'b0;
    logic       load = 1'b0;
    logic [3:0] din = 4'd0;
    logic       term;
    logic [3:0] count;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    updn_load_counter u_dut (
        .clk      (clk),
        .count_en (count_en),
        .clear_n  (clear_n),
        .down     (down),
        .load     (load),
        .din3     (din[3]),
        .din2     (din[2]),
        .din1     (din[1]),
        .din0     (din[0]),
        .term     (term),
        .count    (count)
    );

    // Vector layout: [12] clear_n, [11] load, [10] count_en, [9] down,
    // [8:5] din, [4:1] expected count, [0] expected term.
    localparam int NV = 12;
    localparam logic [12:0] VEC [NV] = '{
        13'b0_0_0_0_0000_0000_0, // R1 clear
        13'b1_1_1_1_1110_1110_0, // R2 load wins over count
        13'b1_0_1_0_0000_1111_1, // R3 up, R7 flag at top
        13'b1_0_1_0_0000_0000_0, // R5 wrap up
        13'b1_0_1_1_0000_1111_0, // R5 wrap down, R7 flag low
        13'b1_0_1_1_0000_1110_0, // R4 down
        13'b1_0_0_0_0000_1110_0, // R6 hold
        13'b1_1_0_0_0001_0001_0, // R2 load with enable low
        13'b1_0_1_1_0000_0000_1, // R4 down to zero, R7 flag
        13'b1_0_0_1_0000_0000_1, // R6 hold, R7 flag ignores enable
        13'b0_1_1_0_1010_0000_0, // R1 clear beats load and count
        13'b1_1_0_0_1111_1111_1  // R2 load top, R7 flag
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic l, input logic e,
                        input logic d, input logic [3:0] v);
        @(negedge clk);
        clear_n = c; load = l; count_en = e; down = d; din = v;
        @(posedge clk);
        #2;
    endtask

    initial begin
        step(1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
        check("R1 reset count", count, 4'd0);
        check("R7 reset term", {3'b0, term}, 4'd0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8:5]);
            check($sformatf("vector %0d count", i), count, VEC[i][4:1]);
            check($sformatf("vector %0d term R7", i), {3'b0, term}, {3'b0, VEC[i][0]});
        end

        // R9: every loadable value steps to its modular neighbours.
        for (int v = 0; v < 16; v++) begin
            step(1'b1, 1'b1, 1'b0, 1'b0, 4'(v));
            check("R9 load", count, 4'(v));
            step(1'b1, 1'b0, 1'b1, 1'b0, 4'd0);
            check("R9 up", count, 4'(v + 1));
            step(1'b1, 1'b1, 1'b0, 1'b1, 4'(v));
            step(1'b1, 1'b0, 1'b1, 1'b1, 4'd0);
            check("R9 down", count, 4'(v + 15));
        end

        // R7: term follows the direction without waiting for an edge.
        step(1'b1, 1'b1, 1'b0, 1'b0, 4'd0);
        check("R7 up at zero", {3'b0, term}, 4'd0);
        down = 1'b1;
        #1;
        check("R7 down at zero, no edge", {3'b0, term}, 4'd1);

        // R8: changes between edges do not move the count.
        step(1'b1, 1'b1, 1'b0, 1'b0, 4'd5);
        clear_n = 1'b0; load = 1'b1; din = 4'd9; count_en = 1'b1;
        #1;
        check("R8 mid-cycle stable", count, 4'd5);
        clear_n = 1'b1; load = 1'b0; count_en = 1'b1; down = 1'b0;
        #1;
        check("R8 still stable", count, 4'd5);
        @(posedge clk);
        #2;
        check("R8 moves at edge", count, 4'd6);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule